// File: doc/BRIEF.md
# Flash Page Buffer Column Port

This block sits between a host and the RAM that stages one flash page. That RAM is 32 bits wide. It holds four 512-byte main areas and, after all of them, four 16-byte spare areas. The host does not address the RAM directly. It loads a column once, and then each byte read, 16-bit read or byte write advances that column automatically. The block turns the logical column into a RAM word address and a byte lane. Columns past the page size land in the spare region, which the block treats as one contiguous run that follows the main page.

Two modes change how the column is interpreted. Spare-only mode pushes a column that lies inside the page into the spare region. Status mode turns a byte read into a return of the device status byte and leaves the RAM untouched. A byte write is a read-modify-write of one RAM word. A write whose column lies past the end of page plus spare is dropped. The flash transfer engine reaches the same RAM through its other port, which this block does not use.

Top module: `pgbuf_port`

## Requirements
- R1: With A the adjusted column (R2), the buffer byte offset is A when A < PAGE_BYTES and 2048 + (A - PAGE_BYTES) otherwise. Byte offset b lives in RAM word b/4, lane b%4, bits [8*(b%4)+7 : 8*(b%4)].
- R2: When spare_only is high and the column is below PAGE_BYTES, the adjusted column is the column plus PAGE_BYTES. Otherwise it is the column itself.
- R3: A byte read (op_code 1) returns the byte at the adjusted column in rd_data[7:0], with rd_data[15:8] = 0.
- R4: After a byte read that is not a status read, col_ptr advances by 1 when bus16 is low and by 2 when it is high. The advance is applied to the column as it was before adjustment.
- R5: A 16-bit read (op_code 2) at byte offset b returns byte b in rd_data[7:0] and byte b+1 in rd_data[15:8]. This holds for every lane, including an odd column whose second byte lies in the next RAM word.
- R6: After a 16-bit read, col_ptr equals the adjusted column plus 2.
- R7: While status_req is high, a byte read returns {8'h00, dev_status_lo}, issues no RAM access and leaves col_ptr unchanged.
- R8: A byte write (op_code 3) whose adjusted column is at or beyond PAGE_BYTES + SPARE_BYTES writes nothing. It leaves col_ptr unchanged and still completes.
- R9: An in-range byte write replaces only the lane selected by the byte offset of R1 and keeps the other three bytes of that RAM word. col_ptr then becomes the adjusted column plus 1.
- R10: Reset clears col_ptr to 0. A set-column op (op_code 0) loads op_col into col_ptr.
- R11: Each accepted op raises done for exactly one cycle, with busy low in that cycle. Latencies from the accepting edge are as follows: set-column, status read and dropped write take 1 edge; byte read, byte write and 16-bit read with lane < 3 take 2 edges; 16-bit read with lane 3 takes 3 edges. The RAM is never read and written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Op request, accepted while busy is low |
| op_code | input | 2 | 0 set column, 1 byte read, 2 16-bit read, 3 byte write |
| op_col | input | COL_W | Column for a set-column op |
| op_wdata | input | 8 | Byte for a byte write |
| spare_only | input | 1 | Spare-only column adjustment |
| bus16 | input | 1 | Device is 16 bits wide (byte-read step 2) |
| status_req | input | 1 | Byte reads return the status byte |
| dev_status_lo | input | 8 | Low byte of the device status word |
| busy | output | 1 | An op is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| col_ptr | output | COL_W | Saved column pointer |
| ram_addr | output | WADDR_W | RAM word address |
| ram_rd | output | 1 | RAM read strobe; data arrives after the next edge |
| ram_rdata | input | 32 | RAM read data |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 32 | RAM write data |

## Verification
A status request and a byte read can arrive in the same op. In that case the status path must win: no RAM strobe, the status byte is returned, and the pointer is frozen. The bench raises status_req at columns where the buffer byte differs from the status byte, and checks the pointer and the latency. Once the flag drops, a plain read at the same column must resume from that column.

The other collision is spare-only adjustment meeting the end-of-region clip. A spare-only write at column 16 adjusts to exactly the end column and must be dropped. The bench judges this case by the pointer and by a final word-by-word comparison of the RAM.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    typedef enum logic [1:0] {
        OP_SETCOL = 2'd0,
        OP_RD8    = 2'd1,
        OP_RD16   = 2'd2,
        OP_WR8    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD8,
        S_RD16,
        S_RD16B,
        S_WR
    } st_e;

endpackage

// File: rtl/pgbuf_colmap.sv
// Column adjustment and mapping onto buffer word address and byte lane.
module pgbuf_colmap #(
    parameter int PAGE_BYTES = 512,
    parameter int MAIN_BYTES = 2048,
    parameter int END_BYTES  = 528,
    parameter int CW         = 11,
    parameter int WAW        = 10
) (
    input  logic [CW-1:0]  col,
    input  logic           spare_only,
    output logic [CW-1:0]  adj_col,
    output logic [WAW-1:0] waddr,
    output logic [1:0]     lane,
    output logic           in_range
);
    localparam int PW = WAW + 2;

    logic [PW-1:0] phys;

    always_comb begin
        adj_col = (spare_only && (col < CW'(PAGE_BYTES))) ? col + CW'(PAGE_BYTES) : col;
        if (adj_col < CW'(PAGE_BYTES))
            phys = PW'(adj_col);
        else
            phys = PW'(adj_col - CW'(PAGE_BYTES)) + PW'(MAIN_BYTES);
        waddr    = phys[PW-1:2];
        lane     = phys[1:0];
        in_range = adj_col < CW'(END_BYTES);
    end
endmodule

// File: rtl/pgbuf_lane.sv
// Byte lane extraction, pair extraction and byte insertion for one RAM word.
module pgbuf_lane (
    input  logic [31:0] word,
    input  logic [1:0]  lane,
    input  logic [7:0]  byte_in,
    output logic [7:0]  byte_out,
    output logic [15:0] pair_out,
    output logic [31:0] word_out
);
    logic [39:0] ext;

    always_comb begin
        ext      = {8'h00, word};
        byte_out = word[{lane, 3'b000} +: 8];
        pair_out = ext[{lane, 3'b000} +: 16];
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign word_out[g*8 +: 8] = (lane == 2'(g)) ? byte_in : word[g*8 +: 8];
    end
endmodule

// File: rtl/pgbuf_port.sv
module pgbuf_port
    import pgbuf_pkg::*;
#(
    parameter int AREAS       = 4,
    parameter int MAIN_AREA   = 512,
    parameter int SPARE_AREA  = 16,
    parameter int PAGE_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    localparam int MAIN_BYTES = AREAS * MAIN_AREA,
    localparam int BUF_BYTES  = AREAS * (MAIN_AREA + SPARE_AREA),
    localparam int END_BYTES  = PAGE_BYTES + SPARE_BYTES,
    localparam int COL_W      = $clog2(2 * PAGE_BYTES) + 1,
    localparam int WADDR_W    = $clog2(BUF_BYTES) - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_code,
    input  logic [COL_W-1:0]   op_col,
    input  logic [7:0]         op_wdata,
    input  logic               spare_only,
    input  logic               bus16,
    input  logic               status_req,
    input  logic [7:0]         dev_status_lo,
    output logic               busy,
    output logic               done,
    output logic [15:0]        rd_data,
    output logic [COL_W-1:0]   col_ptr,
    output logic [WADDR_W-1:0] ram_addr,
    output logic               ram_rd,
    input  logic [31:0]        ram_rdata,
    output logic               ram_we,
    output logic [31:0]        ram_wdata
);
    typedef struct packed {
        st_e                st;
        logic [COL_W-1:0]   col;
        logic [WADDR_W-1:0] waddr;
        logic [1:0]         lane;
        logic [7:0]         hold;
        logic [7:0]         wbyte;
        logic               done;
        logic [15:0]        rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic [COL_W-1:0]   m_adj;
    logic [WADDR_W-1:0] m_waddr;
    logic [1:0]         m_lane;
    logic               m_in_range;
    logic [7:0]         l_byte;
    logic [15:0]        l_pair;
    logic [31:0]        l_word;

    pgbuf_colmap #(
        .PAGE_BYTES(PAGE_BYTES),
        .MAIN_BYTES(MAIN_BYTES),
        .END_BYTES (END_BYTES),
        .CW        (COL_W),
        .WAW       (WADDR_W)
    ) u_map (
        .col       (r_q.col),
        .spare_only(spare_only),
        .adj_col   (m_adj),
        .waddr     (m_waddr),
        .lane      (m_lane),
        .in_range  (m_in_range)
    );

    pgbuf_lane u_lane (
        .word    (ram_rdata),
        .lane    (r_q.lane),
        .byte_in (r_q.wbyte),
        .byte_out(l_byte),
        .pair_out(l_pair),
        .word_out(l_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        ram_rd    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = r_q.waddr;
        ram_wdata = l_word;
        unique case (r_q.st)
            S_IDLE: begin
                if (op_valid) begin
                    unique case (op_e'(op_code))
                        OP_SETCOL: begin
                            r_d.col  = op_col;
                            r_d.done = 1'b1;
                        end
                        OP_RD8: begin
                            if (status_req) begin
                                r_d.rdata = {8'h00, dev_status_lo};
                                r_d.done  = 1'b1;
                            end else begin
                                ram_rd    = 1'b1;
                                ram_addr  = m_waddr;
                                r_d.waddr = m_waddr;
                                r_d.lane  = m_lane;
                                r_d.col   = r_q.col + (bus16 ? COL_W'(2) : COL_W'(1));
                                r_d.st    = S_RD8;
                            end
                        end
                        OP_RD16: begin
                            ram_rd    = 1'b1;
                            ram_addr  = m_waddr;
                            r_d.waddr = m_waddr;
                            r_d.lane  = m_lane;
                            r_d.col   = m_adj + COL_W'(2);
                            r_d.st    = S_RD16;
                        end
                        OP_WR8: begin
                            if (m_in_range) begin
                                ram_rd    = 1'b1;
                                ram_addr  = m_waddr;
                                r_d.waddr = m_waddr;
                                r_d.lane  = m_lane;
                                r_d.wbyte = op_wdata;
                                r_d.col   = m_adj + COL_W'(1);
                                r_d.st    = S_WR;
                            end else begin
                                r_d.done = 1'b1;
                            end
                        end
                        default: r_d.done = 1'b1;
                    endcase
                end
            end
            S_RD8: begin
                r_d.rdata = {8'h00, l_byte};
                r_d.done  = 1'b1;
                r_d.st    = S_IDLE;
            end
            S_RD16: begin
                if (r_q.lane == 2'd3) begin
                    r_d.hold  = l_byte;
                    ram_rd    = 1'b1;
                    ram_addr  = r_q.waddr + WADDR_W'(1);
                    r_d.waddr = r_q.waddr + WADDR_W'(1);
                    r_d.st    = S_RD16B;
                end else begin
                    r_d.rdata = l_pair;
                    r_d.done  = 1'b1;
                    r_d.st    = S_IDLE;
                end
            end
            S_RD16B: begin
                r_d.rdata = {ram_rdata[7:0], r_q.hold};
                r_d.done  = 1'b1;
                r_d.st    = S_IDLE;
            end
            S_WR: begin
                ram_we   = 1'b1;
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy    = (r_q.st != S_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rdata;
    assign col_ptr = r_q.col;

    // R11: RAM strobes never overlap
    a_r11_rd_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_we));

    // R11: completion pulse only when idle
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: status read completes next edge without moving the pointer
    a_r7_status_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_code == OP_RD8 && status_req)
        |=> (done && col_ptr == $past(col_ptr)));

    // R7: no RAM access for a status read
    a_r7_status_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_code == OP_RD8 && status_req) |-> !ram_rd);

    // R10: set-column loads the pointer
    a_r10_setcol: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_code == OP_SETCOL) |=> col_ptr == $past(op_col));

    // R8: out-of-range write is dropped with the pointer held
    a_r8_clip_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_valid && op_code == OP_WR8 && !m_in_range)
        |=> (done && !busy && col_ptr == $past(col_ptr)));

    // R9: a RAM write follows a read of the same word
    a_r9_rmw: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(ram_rd) && ram_addr == $past(ram_addr)));
endmodule

// File: tb/sim_pgbuf_port.sv
module sim_pgbuf_port;
    localparam int CW    = 11;
    localparam int NW    = 528;
    localparam int NB    = 2112;
    localparam int PAGE  = 512;
    localparam int ENDC  = 528;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [1:0]    op_code = 2'd0;
    logic [CW-1:0] op_col = '0;
    logic [7:0]    op_wdata = 8'h00;
    logic          spare_only = 1'b0;
    logic          bus16 = 1'b0;
    logic          status_req = 1'b0;
    logic [7:0]    dev_status_lo = 8'h00;
    logic          busy, done;
    logic [15:0]   rd_data;
    logic [CW-1:0] col_ptr;
    logic [9:0]    ram_addr;
    logic          ram_rd, ram_we;
    logic [31:0]   ram_rdata = 32'h0;
    logic [31:0]   ram_wdata;

    logic [31:0] mem [0:NW-1];
    logic [7:0]  mb  [0:NB-1];
    int n_chk = 0;
    int n_fail = 0;
    int lat;

    always #5 clk = ~clk;

    pgbuf_port u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_col(op_col), .op_wdata(op_wdata), .spare_only(spare_only),
        .bus16(bus16), .status_req(status_req), .dev_status_lo(dev_status_lo),
        .busy(busy), .done(done), .rd_data(rd_data), .col_ptr(col_ptr),
        .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_rdata(ram_rdata),
        .ram_we(ram_we), .ram_wdata(ram_wdata)
    );

    always @(posedge clk) begin
        if (ram_we && ram_addr < NW) mem[ram_addr] <= ram_wdata;
        if (ram_rd) ram_rdata <= (ram_addr < NW) ? mem[ram_addr] : 32'h0;
    end

    function automatic int phys(input int c);
        return (c < PAGE) ? c : 2048 + c - PAGE;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] code, input int c, input logic [7:0] wb);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_col = CW'(c); op_wdata = wb;
        @(posedge clk); #1;
        op_valid = 1'b0;
        lat = 1;
        for (int k = 0; k < 20 && !done; k++) begin
            @(posedge clk); #1;
            lat++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 actual=no-done expected=done");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) mb[i] = 8'((i * 7) + ((i >> 8) * 13) + 3);
        for (int w = 0; w < NW; w++) mem[w] = {mb[4*w+3], mb[4*w+2], mb[4*w+1], mb[4*w]};
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset col", int'(col_ptr), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset done", int'(done), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 R3 R4: sequential byte sweep over page and spare, 8-bit device
        do_op(2'd0, 0, 8'h00);
        chk("R11 setcol latency", lat, 1);
        for (int i = 0; i < ENDC; i++) begin
            do_op(2'd1, 0, 8'h00);
            chk("R3 byte read", int'(rd_data), int'(mb[phys(i)]));
            chk("R4 step 1", int'(col_ptr), i + 1);
        end
        chk("R11 byte read latency", lat, 2);

        // R4: 16-bit device steps by 2
        bus16 = 1'b1;
        do_op(2'd0, 3, 8'h00);
        for (int j = 0; j < 20; j++) begin
            do_op(2'd1, 0, 8'h00);
            chk("R4 bus16 data", int'(rd_data), int'(mb[phys(3 + 2*j)]));
            chk("R4 step 2", int'(col_ptr), 5 + 2*j);
        end
        bus16 = 1'b0;

        // R5 R6: 16-bit read at every column
        for (int c = 0; c < ENDC; c++) begin
            do_op(2'd0, c, 8'h00);
            do_op(2'd2, 0, 8'h00);
            chk("R5 word read", int'(rd_data), {24'h0, mb[phys(c) + 1]} * 256 + int'(mb[phys(c)]));
            chk("R6 col after word", int'(col_ptr), c + 2);
            chk("R11 word latency", lat, ((phys(c) % 4) == 3) ? 3 : 2);
        end

        // R2: spare-only adjustment
        spare_only = 1'b1;
        for (int c = 0; c < 16; c++) begin
            do_op(2'd0, c, 8'h00);
            do_op(2'd1, 0, 8'h00);
            chk("R2 spare byte", int'(rd_data), int'(mb[2048 + c]));
            chk("R2 spare byte col", int'(col_ptr), c + 1);
            if (c < 15) begin
                do_op(2'd0, c, 8'h00);
                do_op(2'd2, 0, 8'h00);
                chk("R2 spare word", int'(rd_data), int'(mb[2049 + c]) * 256 + int'(mb[2048 + c]));
                chk("R2 R6 spare word col", int'(col_ptr), c + PAGE + 2);
            end
        end
        do_op(2'd0, 520, 8'h00);
        do_op(2'd1, 0, 8'h00);
        chk("R2 no adjust above page", int'(rd_data), int'(mb[phys(520)]));
        chk("R2 col above page", int'(col_ptr), 521);
        spare_only = 1'b0;

        // R7: status request collides with byte read
        do_op(2'd0, 37, 8'h00);
        status_req = 1'b1;
        for (int s = 0; s < 4; s++) begin
            dev_status_lo = 8'(8'hA5 ^ (s * 8'h33));
            bus16 = s[0];
            do_op(2'd1, 0, 8'h00);
            chk("R7 status data", int'(rd_data), int'(8'hA5 ^ (s * 8'h33)) & 255);
            chk("R7 col frozen", int'(col_ptr), 37);
            chk("R7 latency", lat, 1);
        end
        status_req = 1'b0; bus16 = 1'b0;
        do_op(2'd1, 0, 8'h00);
        chk("R7 resume data", int'(rd_data), int'(mb[37]));
        chk("R7 resume col", int'(col_ptr), 38);

        // R9: byte writes across lanes and regions
        begin
            int wl [14] = '{0, 1, 2, 3, 4, 5, 6, 7, 101, 102, 511, 512, 515, 527};
            foreach (wl[k]) begin
                logic [7:0] v;
                v = 8'(wl[k] * 29 + 8'h5A);
                do_op(2'd0, wl[k], 8'h00);
                do_op(2'd3, 0, v);
                chk("R9 write col", int'(col_ptr), wl[k] + 1);
                chk("R11 write latency", lat, 2);
                mb[phys(wl[k])] = v;
                do_op(2'd0, wl[k] & ~3, 8'h00);
                for (int q = 0; q < 4; q++) begin
                    do_op(2'd1, 0, 8'h00);
                    chk("R9 lane readback", int'(rd_data), int'(mb[phys((wl[k] & ~3) + q)]));
                end
            end
        end

        // R2 R9: spare-only write
        spare_only = 1'b1;
        do_op(2'd0, 5, 8'h00);
        do_op(2'd3, 0, 8'hC3);
        mb[2053] = 8'hC3;
        chk("R2 R9 spare write col", int'(col_ptr), PAGE + 6);
        // R8: spare-only column that adjusts exactly to the end
        do_op(2'd0, 16, 8'h00);
        do_op(2'd3, 0, 8'hEE);
        chk("R8 spare clip col", int'(col_ptr), 16);
        chk("R8 spare clip latency", lat, 1);
        spare_only = 1'b0;

        // R8: writes past the end are dropped
        do_op(2'd0, ENDC, 8'h00);
        do_op(2'd3, 0, 8'h77);
        chk("R8 clip col", int'(col_ptr), ENDC);
        do_op(2'd0, 700, 8'h00);
        do_op(2'd3, 0, 8'h78);
        chk("R8 far clip col", int'(col_ptr), 700);
        do_op(2'd0, ENDC - 1, 8'h00);
        do_op(2'd1, 0, 8'h00);
        chk("R8 last byte intact", int'(rd_data), int'(mb[phys(ENDC - 1)]));

        // R8 R9: whole RAM matches model
        begin
            int bad = 0;
            for (int w = 0; w < NW; w++)
                if (mem[w] !== {mb[4*w+3], mb[4*w+2], mb[4*w+1], mb[4*w]}) bad++;
            chk("R8 R9 ram mismatches", bad, 0);
        end

        // R10: set column after activity
        do_op(2'd0, 300, 8'h00);
        chk("R10 set col", int'(col_ptr), 300);

        @(negedge clk);
        summary();
        $finish;
    end
endmodule